// File: doc/BRIEF.md
# Eight-Channel Block Transfer Engine

This block copies bytes between a wide memory bus (24-bit address, called the A side) and a narrow peripheral bus (8-bit register offset, called the B side). Each of its channels carries a direction, a transfer mode, a B-side base offset, a 16-bit address with an 8-bit bank, two address-stepping flags and a 16-bit byte count. A host loads the channel settings through a single-word load port, then pulses a start strobe with a channel mask. The engine works through the selected channels in turn, generating the B-side offset pattern of each mode, stepping the A-side address, and dropping any access that would land on internal register windows or would copy between the two views of the same work RAM.

Timing is fixed: a lead-in of 8 clocks, then 8 clocks per byte (a 4-clock read half and a 4-clock write half), then an 8-clock tail after each channel. The write of one byte is held in a one-entry pipe and reaches the bus after the read of the next byte; the lead-in and every tail flush that pipe.

Top module: `dma_block_engine`

## Requirements
- R1: After reset every channel register reads back as all ones (54'h3F_FFFF_FFFF_FFFF), `busy` is low and no bus strobe is raised.
- R2: The load word is packed as count[15:0], address[31:16], bank[39:32], base offset[47:40], mode[50:48], reverse flag[51], fixed flag[52], direction[53]; `cfg_rdata` shows the live register of channel `cfg_ch`, and loads presented while `busy` is high are ignored.
- R3: A start with a nonzero mask while idle raises `busy` at the next edge; a start while busy is ignored; selected channels run one at a time in ascending index order, each emitting one `ch_done` pulse in the last cycle of its tail, after which its enable is cleared.
- R4: The B-side offset is base plus a term chosen by mode and byte index k: mode 0, 2, 6 give 0; modes 1 and 5 give k mod 2; modes 3 and 7 give bit 1 of k; mode 4 gives k mod 4.
- R5: The A-side address is {bank, address}; the 16-bit part increments after each byte, decrements when the reverse flag is set, and holds when the fixed flag is set; the bank never changes.
- R6: The count decrements after each byte and the channel ends after the byte that takes it to zero; a count of 0 runs 65536 bytes, so after the first byte it reads 16'hFFFF with `busy` still high.
- R7: `busy` stays high for 8 + sum over channels of (8·n + 8) cycles; the write of byte N is issued after the read of byte N+1, and the last write of a channel is issued at the end of its tail; no two strobes share a cycle.
- R8: Direction 0 reads the A side and writes the B side at the same offset pattern; direction 1 reads the B side and writes the A side.
- R9: With bank bit 6 clear, A-side addresses whose low 16 bits fall in 2100–21FF, 4000–421F or 4300–437F are invalid: such a read raises no strobe and yields 0x00, and such a write raises no strobe.
- R10: When the B-side offset is 0x80 and the A-side address is in bank 7E or 7F, or has bank bit 6 clear and low 16 bits below 2000, the B-side access is suppressed (a read yields 0x00, a write is dropped) while the A-side half still takes place if valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Load strobe for one channel register |
| cfg_ch | input | CHW | Channel selected for load and readback |
| cfg_wdata | input | 54 | Packed channel settings |
| cfg_rdata | output | 54 | Live settings of the selected channel |
| start | input | 1 | Start strobe |
| start_mask | input | NCH | Channels to run |
| a_rd | output | 1 | A-side read strobe |
| a_wr | output | 1 | A-side write strobe |
| a_addr | output | 24 | A-side address |
| a_wdata | output | 8 | A-side write data |
| a_rdata | input | 8 | A-side read data, valid in the strobe cycle |
| b_rd | output | 1 | B-side read strobe |
| b_wr | output | 1 | B-side write strobe |
| b_addr | output | 8 | B-side register offset |
| b_wdata | output | 8 | B-side write data |
| b_rdata | input | 8 | B-side read data, valid in the strobe cycle |
| busy | output | 1 | High while a run is in progress |
| ch_done | output | NCH | One-cycle completion pulse per channel |

## Verification
A wrong phase counter or byte count shows at once as a `busy` window of the wrong length and as strobes in the wrong cycles, since every strobe sits at a fixed offset from the start. A wrong offset pattern, address step or guard decision appears on the first affected byte as a strobe with the wrong address, a missing strobe, or a write carrying the wrong data, and a wrong write pipe shows one byte later as a misordered or lost write. Stale channel state after a run is visible through the readback port as a count other than zero or an address not advanced by the byte total.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
   typedef struct packed {
      logic        dir;
      logic        fixed;
      logic        rev;
      logic [2:0]  mode;
      logic [7:0]  base;
      logic [7:0]  bank;
      logic [15:0] addr;
      logic [15:0] count;
   } chan_cfg_t;

   localparam int CFG_W = $bits(chan_cfg_t);

   typedef enum logic [2:0] {PH_IDLE, PH_LEAD, PH_RD, PH_WR, PH_TAIL} phase_t;

   typedef struct packed {
      logic        vld;
      logic        to_b;
      logic [23:0] addr;
      logic [7:0]  data;
   } wpipe_t;
endpackage

// File: rtl/dma_boff.sv
module dma_boff (
   input  logic [2:0] mode,
   input  logic [1:0] idx,
   output logic [1:0] off
);
   always_comb begin
      unique case (mode)
         3'd1, 3'd5: off = {1'b0, idx[0]};
         3'd3, 3'd7: off = {1'b0, idx[1]};
         3'd4:       off = idx;
         default:    off = 2'd0;
      endcase
   end
endmodule

// File: rtl/dma_guard.sv
module dma_guard (
   input  logic [23:0] a,
   input  logic [7:0]  b,
   output logic        a_bad,
   output logic        pair_bad
);
   logic low_bank;
   assign low_bank = ~a[22];

   assign a_bad = low_bank &&
                  ((a[15:8] == 8'h21) ||
                   (a[15:9] == 7'h20) ||
                   (a[15:5] == 11'h210) ||
                   (a[15:7] == 9'h086));

   assign pair_bad = (b == 8'h80) &&
                     ((a[23:17] == 7'h3F) || (low_bank && a[15:13] == 3'd0));
endmodule

// File: rtl/dma_pick.sv
module dma_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/dma_block_engine.sv
module dma_block_engine
   import dma_blk_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int CHW       = (NCH > 1) ? $clog2(NCH) : 1,
   parameter int HALF_CLKS = 4,
   parameter int OVH_CLKS  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CHW-1:0]   cfg_ch,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             start,
   input  logic [NCH-1:0]   start_mask,
   output logic             a_rd,
   output logic             a_wr,
   output logic [23:0]      a_addr,
   output logic [7:0]       a_wdata,
   input  logic [7:0]       a_rdata,
   output logic             b_rd,
   output logic             b_wr,
   output logic [7:0]       b_addr,
   output logic [7:0]       b_wdata,
   input  logic [7:0]       b_rdata,
   output logic             busy,
   output logic [NCH-1:0]   ch_done
);
   localparam int LONGEST = (OVH_CLKS > HALF_CLKS) ? OVH_CLKS : HALF_CLKS;
   localparam int TW      = $clog2(LONGEST) + 1;

   if (NCH < 1 || (1 << CHW) < NCH) begin : g_bad_nch
      $error("dma_block_engine: NCH does not fit CHW");
   end
   if (HALF_CLKS < 1 || OVH_CLKS < 1) begin : g_bad_time
      $error("dma_block_engine: phase lengths must be positive");
   end

   chan_cfg_t        regs [NCH];
   logic [NCH-1:0]   en;
   logic [CHW-1:0]   cur;
   phase_t           ph;
   logic [TW-1:0]    tick;
   logic [TW-1:0]    lim_m1;
   logic [1:0]       idx;
   logic [7:0]       mdr;
   wpipe_t           pipe;
   logic             busy_q;

   chan_cfg_t        cc;
   logic [23:0]      cur_a;
   logic [1:0]       off;
   logic [7:0]       b_now;
   logic             a_bad, pair_bad, rd_ok, wr_ok, last;
   logic             rd_fire, wr_fire;
   logic [NCH-1:0]   rest;
   logic [CHW-1:0]   nxt, first;
   logic             more, any_start;

   assign cc    = regs[cur];
   assign cur_a = {cc.bank, cc.addr};
   assign b_now = cc.base + {6'd0, off};
   assign cfg_rdata = regs[cfg_ch];

   dma_boff  u_boff  (.mode(cc.mode), .idx(idx), .off(off));
   dma_guard u_guard (.a(cur_a), .b(b_now), .a_bad(a_bad), .pair_bad(pair_bad));

   always_comb begin
      rest      = en;
      rest[cur] = 1'b0;
   end
   dma_pick #(.N(NCH), .IW(CHW)) u_next  (.req(rest),       .idx(nxt),   .any(more));
   dma_pick #(.N(NCH), .IW(CHW)) u_first (.req(start_mask), .idx(first), .any(any_start));

   assign rd_ok   = cc.dir ? !pair_bad : !a_bad;
   assign wr_ok   = cc.dir ? !a_bad    : !pair_bad;
   assign lim_m1  = (ph == PH_LEAD || ph == PH_TAIL) ? TW'(OVH_CLKS - 1) : TW'(HALF_CLKS - 1);
   assign last    = (tick == lim_m1);
   assign rd_fire = (ph == PH_RD) && last && rd_ok;
   assign wr_fire = (ph == PH_LEAD || ph == PH_WR || ph == PH_TAIL) && last && pipe.vld;

   assign a_rd    = rd_fire && !cc.dir;
   assign b_rd    = rd_fire &&  cc.dir;
   assign a_wr    = wr_fire && !pipe.to_b;
   assign b_wr    = wr_fire &&  pipe.to_b;
   assign a_addr  = a_wr ? pipe.addr : cur_a;
   assign b_addr  = b_wr ? pipe.addr[7:0] : b_now;
   assign a_wdata = pipe.data;
   assign b_wdata = pipe.data;
   assign busy    = busy_q;

   always_comb begin
      ch_done = '0;
      if (ph == PH_TAIL && last) ch_done[cur] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) regs[i] <= '1;
         en     <= '0;
         cur    <= '0;
         ph     <= PH_IDLE;
         tick   <= '0;
         idx    <= '0;
         mdr    <= '0;
         pipe   <= '0;
         busy_q <= 1'b0;
      end else begin
         tick <= (last || ph == PH_IDLE) ? '0 : tick + 1'b1;
         unique case (ph)
            PH_IDLE: begin
               if (cfg_we && int'(cfg_ch) < NCH) regs[cfg_ch] <= chan_cfg_t'(cfg_wdata);
               if (start && any_start) begin
                  en     <= start_mask;
                  cur    <= first;
                  ph     <= PH_LEAD;
                  busy_q <= 1'b1;
               end
            end
            PH_LEAD: if (last) begin
               pipe.vld <= 1'b0;
               idx      <= '0;
               ph       <= PH_RD;
            end
            PH_RD: if (last) begin
               mdr <= rd_ok ? (cc.dir ? b_rdata : a_rdata) : 8'h00;
               ph  <= PH_WR;
            end
            PH_WR: if (last) begin
               pipe.vld  <= wr_ok;
               pipe.to_b <= !cc.dir;
               pipe.addr <= cc.dir ? cur_a : {16'h0000, b_now};
               pipe.data <= mdr;
               if (!cc.fixed) regs[cur].addr <= cc.rev ? cc.addr - 16'd1 : cc.addr + 16'd1;
               regs[cur].count <= cc.count - 16'd1;
               idx <= idx + 2'd1;
               ph  <= (cc.count == 16'd1) ? PH_TAIL : PH_RD;
            end
            PH_TAIL: if (last) begin
               pipe.vld <= 1'b0;
               en[cur]  <= 1'b0;
               idx      <= '0;
               if (more) begin
                  cur <= nxt;
                  ph  <= PH_RD;
               end else begin
                  ph     <= PH_IDLE;
                  busy_q <= 1'b0;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({a_rd, a_wr, b_rd, b_wr}));

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(a_rd || a_wr || b_rd || b_wr || (|ch_done)));

   // R3
   done_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_done) |=> ((en & $past(ch_done)) == '0));

   // R3
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(|ch_done));

   // R9
   window_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && !a_addr[22]) |-> (a_addr[15:8] != 8'h21 && a_addr[15:7] != 9'h086));
endmodule

// File: tb/tb_dma_block_engine.sv
module tb_dma_block_engine;
   import dma_blk_pkg::*;

   localparam int CLK_P = 10;
   localparam int NCH   = 8;
   localparam int WD    = 190000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [2:0]       cfg_ch = '0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic [CFG_W-1:0] cfg_rdata;
   logic             start = 1'b0;
   logic [NCH-1:0]   start_mask = '0;
   logic             a_rd, a_wr, b_rd, b_wr, busy;
   logic [23:0]      a_addr;
   logic [7:0]       a_wdata, a_rdata, b_addr, b_wdata, b_rdata;
   logic [NCH-1:0]   ch_done;

   always #(CLK_P / 2) clk = ~clk;

   function automatic logic [7:0] amem(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
   endfunction
   function automatic logic [7:0] bmem(input logic [7:0] b);
      return b ^ 8'hC3;
   endfunction
   assign a_rdata = amem(a_addr);
   assign b_rdata = bmem(b_addr);

   dma_block_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .start(start),
      .start_mask(start_mask), .a_rd(a_rd), .a_wr(a_wr), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_rdata(a_rdata), .b_rd(b_rd), .b_wr(b_wr),
      .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .busy(busy),
      .ch_done(ch_done));

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD && !finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, WD);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- bench model ----------------
   chan_cfg_t   sh [NCH];
   logic [1:0]  ek [0:2047];
   logic [23:0] ea [0:2047];
   logic [7:0]  ed [0:2047];
   int          ne, ni, nd, bcyc, exp_busy;
   int          dord [0:15];
   int          eord [0:15];
   int          neo;
   bit          mon_on = 0;

   function automatic logic [1:0] bo(input logic [2:0] m, input int k);
      case (m)
         3'd4:       return 2'(k & 3);
         3'd1, 3'd5: return 2'(k & 1);
         3'd3, 3'd7: return 2'((k >> 1) & 1);
         default:    return 2'd0;
      endcase
   endfunction
   function automatic bit abad(input logic [23:0] a);
      logic [15:0] lo;
      lo = a[15:0];
      if (a[22]) return 0;
      return (lo >= 16'h2100 && lo <= 16'h21FF) || (lo >= 16'h4000 && lo <= 16'h421F) ||
             (lo >= 16'h4300 && lo <= 16'h437F);
   endfunction
   function automatic bit pbad(input logic [7:0] b, input logic [23:0] a);
      if (b != 8'h80) return 0;
      return (a[23:16] == 8'h7E) || (a[23:16] == 8'h7F) || (!a[22] && a[15:0] < 16'h2000);
   endfunction

   task automatic push(input logic [1:0] k, input logic [23:0] a, input logic [7:0] d);
      ek[ne] = k; ea[ne] = a; ed[ne] = d; ne++;
   endtask

   // kinds: 0 A read, 1 A write, 2 B read, 3 B write
   task automatic build(input logic [NCH-1:0] m);
      bit pv; logic [1:0] pk; logic [23:0] pa; logic [7:0] pd;
      ne = 0; neo = 0; exp_busy = 8; pv = 0; pk = 0; pa = 0; pd = 0;
      for (int ch = 0; ch < NCH; ch++) begin
         if (m[ch]) begin
            chan_cfg_t c;
            int n;
            c = sh[ch];
            n = int'(c.count);
            for (int k = 0; k < n; k++) begin
               logic [23:0] a; logic [7:0] b, d; bit rok, wok;
               a = {c.bank, c.addr};
               b = c.base + {6'd0, bo(c.mode, k)};
               if (!c.dir) begin
                  rok = !abad(a); wok = !pbad(b, a);
                  d = rok ? amem(a) : 8'h00;
                  if (rok) push(2'd0, a, d);
               end else begin
                  rok = !pbad(b, a); wok = !abad(a);
                  d = rok ? bmem(b) : 8'h00;
                  if (rok) push(2'd2, {16'h0, b}, d);
               end
               if (pv) push(pk, pa, pd);
               pv = wok; pk = c.dir ? 2'd1 : 2'd3; pa = c.dir ? a : {16'h0, b}; pd = d;
               if (!c.fixed) c.addr = c.rev ? c.addr - 16'd1 : c.addr + 16'd1;
            end
            if (pv) push(pk, pa, pd);
            pv = 0;
            c.count = 16'd0;
            sh[ch] = c;
            exp_busy += 8 * n + 8;
            eord[neo] = ch; neo++;
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         if (busy) bcyc++;
         if (a_rd || a_wr || b_rd || b_wr) begin
            logic [1:0] k; logic [23:0] ad; logic [7:0] dt;
            k  = a_rd ? 2'd0 : a_wr ? 2'd1 : b_rd ? 2'd2 : 2'd3;
            ad = (k < 2) ? a_addr : {16'h0, b_addr};
            dt = a_wr ? a_wdata : b_wdata;
            if (ni >= ne) chk(0, "R7 unexpected strobe", {k, ad}, 0);
            else begin
               chk(k == ek[ni] && ad == ea[ni], "R4 R5 R7 R8 R9 R10 strobe kind/address",
                   {k, ad}, {ek[ni], ea[ni]});
               if (k == 2'd1 || k == 2'd3)
                  chk(dt == ed[ni], "R8 R9 R10 write data", dt, ed[ni]);
            end
            ni++;
         end
         for (int i = 0; i < NCH; i++) if (ch_done[i]) begin
            if (nd < 16) dord[nd] = i;
            nd++;
         end
      end
   end

   task automatic load(input int ch, input chan_cfg_t c);
      @(negedge clk);
      cfg_we = 1; cfg_ch = 3'(ch); cfg_wdata = c;
      @(negedge clk);
      cfg_we = 0;
      sh[ch] = c;
   endtask

   task automatic readback(input int ch, input string tag);
      @(negedge clk);
      cfg_ch = 3'(ch);
      #1;
      chk(cfg_rdata == sh[ch], tag, cfg_rdata, sh[ch]);
   endtask

   task automatic run_job(input logic [NCH-1:0] m, input bit poke);
      build(m);
      ni = 0; nd = 0; bcyc = 0; mon_on = 1;
      @(negedge clk);
      start = 1; start_mask = m;
      @(negedge clk);
      start = 0;
      chk(busy == 1'b1, "R3 busy after start", busy, 1);
      if (poke) begin
         chan_cfg_t junk;
         junk = '0; junk.count = 16'd3;
         cfg_we = 1; cfg_ch = 3'd7; cfg_wdata = junk;
         start = 1; start_mask = 8'h80;
         @(negedge clk);
         cfg_we = 0; start = 0;
      end
      while (busy) @(negedge clk);
      mon_on = 0;
      chk(ni == ne, "R7 strobe total", ni, ne);
      chk(bcyc == exp_busy, "R7 busy length", bcyc, exp_busy);
      chk(nd == neo, "R3 done pulse total", nd, neo);
      for (int i = 0; i < neo && i < nd; i++)
         chk(dord[i] == eord[i], "R3 service order", dord[i], eord[i]);
      for (int ch = 0; ch < NCH; ch++)
         if (m[ch]) readback(ch, "R5 R6 registers after run");
   endtask

   function automatic chan_cfg_t mk(input bit dir, fixed, rev, input logic [2:0] mode,
                                    input logic [7:0] base, bank, input logic [15:0] addr, cnt);
      chan_cfg_t c;
      c.dir = dir; c.fixed = fixed; c.rev = rev; c.mode = mode; c.base = base;
      c.bank = bank; c.addr = addr; c.count = cnt;
      return c;
   endfunction

   initial begin
      void'($urandom(32'h00C0FFEE));
      for (int i = 0; i < NCH; i++) sh[i] = '1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      for (int i = 0; i < NCH; i++) readback(i, "R1 reset register value");
      chk(busy == 0 && !(a_rd | a_wr | b_rd | b_wr), "R1 idle outputs",
          {busy, a_rd, a_wr, b_rd, b_wr}, 0);
      // R2 load and readback, field positions
      load(3, mk(1, 0, 1, 3'd5, 8'h18, 8'h01, 16'hABCD, 16'd7));
      readback(3, "R2 load readback");
      chk(cfg_rdata[53] == 1 && cfg_rdata[50:48] == 3'd5 && cfg_rdata[47:40] == 8'h18 &&
          cfg_rdata[31:16] == 16'hABCD, "R2 field positions", cfg_rdata, sh[3]);
      // R4 R8 mode 4, A to B
      load(2, mk(0, 0, 0, 3'd4, 8'h18, 8'h01, 16'h8000, 16'd8));
      run_job(8'h04, 0);
      // R5 R8 reverse, mode 3, B to A
      load(2, mk(1, 0, 1, 3'd3, 8'h30, 8'hC2, 16'h0001, 16'd5));
      run_job(8'h04, 0);
      // R5 fixed address, mode 1
      load(4, mk(0, 1, 0, 3'd1, 8'h04, 8'h05, 16'h9000, 16'd4));
      run_job(8'h10, 0);
      // R9 invalid read window, invalid write window
      load(0, mk(0, 0, 0, 3'd0, 8'h22, 8'h00, 16'h21FE, 16'd4));
      load(1, mk(1, 0, 0, 3'd0, 8'h22, 8'h80, 16'h437E, 16'd4));
      run_job(8'h03, 0);
      // R10 RAM to RAM suppression
      load(5, mk(0, 0, 0, 3'd0, 8'h80, 8'h7E, 16'h1234, 16'd2));
      load(6, mk(1, 0, 0, 3'd2, 8'h80, 8'h00, 16'h1FFF, 16'd2));
      run_job(8'h60, 0);
      // R3 ordering across channels, busy-time load and start ignored
      load(7, mk(0, 0, 0, 3'd0, 8'h01, 8'h03, 16'h0100, 16'd2));
      load(1, mk(0, 0, 0, 3'd6, 8'h40, 8'h02, 16'h5000, 16'd3));
      load(5, mk(1, 0, 0, 3'd7, 8'h50, 8'h02, 16'h6000, 16'd4));
      load(6, mk(0, 1, 1, 3'd4, 8'h60, 8'h02, 16'h7000, 16'd1));
      run_job(8'h62, 1);
      readback(7, "R2 R3 channel untouched by busy-time load and start");
      // randomized jobs
      for (int j = 0; j < 20; j++) begin
         logic [NCH-1:0] m;
         m = 8'($urandom_range(1, 255));
         for (int ch = 0; ch < NCH; ch++) if (m[ch]) begin
            chan_cfg_t c;
            int sel;
            c = chan_cfg_t'({$urandom, $urandom});
            sel = $urandom_range(0, 5);
            c.bank = (sel == 0) ? 8'h7F : (sel == 1) ? 8'h00 : (sel == 2) ? 8'h40 : 8'($urandom);
            sel = $urandom_range(0, 4);
            if (sel == 0) c.addr = 16'h2100 + 16'($urandom_range(0, 300));
            else if (sel == 1) c.addr = 16'h41FE + 16'($urandom_range(0, 40));
            else if (sel == 2) c.addr = 16'h436E + 16'($urandom_range(0, 40));
            if ($urandom_range(0, 2) == 0) c.base = 8'h7E;
            c.count = 16'($urandom_range(1, 5));
            load(ch, c);
         end
         run_job(m, 0);
      end
      // R6 count of zero runs past its first byte
      load(0, mk(0, 0, 0, 3'd0, 8'h10, 8'h01, 16'h8000, 16'd0));
      @(negedge clk);
      start = 1; start_mask = 8'h01;
      @(negedge clk);
      start = 0;
      repeat (17) @(negedge clk);
      cfg_ch = 3'd0;
      #1;
      chk(cfg_rdata[15:0] == 16'hFFFF && busy == 1, "R6 zero count continues",
          {busy, cfg_rdata[15:0]}, {1'b1, 16'hFFFF});
      chk(cfg_rdata[31:16] == 16'h8001, "R5 address after first byte", cfg_rdata[31:16], 16'h8001);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < NCH; i++) sh[i] = '1;
      for (int i = 0; i < NCH; i++) readback(i, "R1 register value after second reset");
      chk(busy == 0, "R1 busy after second reset", busy, 0);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule